// File: doc/BRIEF.md
# Cycle and Retired-Instruction Counter CSR Unit

This block holds the two free-running event counters of a 32-bit RISC-V core: one that advances on every clock, and one that advances each time an instruction retires. Each counter is exposed through CSR space as a low word and a high word. Machine-level addresses allow reads and writes. User-level aliases of the same words are read-only.

The parameter `CNT_W` sets the implemented width of each counter, from 0 to 64. Bits above `CNT_W` are fixed at zero and carries stop there. When the width is below 32, the high words are removed from the address map. Two constant status outputs report a reduced width and the complete absence of counters. Widths below 64 are a deliberate departure from the standard counter width, and the block supports them.

CSR access is combinational. The core presents an address with a read or write strobe in one cycle and gets read data and an illegal-access flag back in that same cycle. A legal write takes effect at the next clock edge.

Top module: `cnt_csr_unit`

## Requirements
- R1: After the asynchronous reset (rst_ni low), both counters hold zero. A read in the first cycle after release returns 0.
- R2: The cycle counter increments by one at every clock edge unless inhibit_i[0] is 1. While inhibit_i[0] is 1, the cycle counter holds its value.
- R3: The retire counter increments by one at each clock edge where retire_i is 1 and inhibit_i[1] is 0. In every other cycle it holds its value.
- R4: A carry out of bit 31 propagates into the high word. The counter wraps to zero at 2^CNT_W, so no bit at or above CNT_W is ever set.
- R5: A legal write to a machine address replaces the implemented bits of the addressed word at the next edge. In that cycle the write takes priority over the increment of that counter, and the other word keeps its value. Machine addresses: 0xB00 is cycle bits 31:0, 0xB80 is cycle bits 63:32, 0xB02 is retire bits 31:0, 0xB82 is retire bits 63:32.
- R6: Read data bits that correspond to counter bits at or above CNT_W always read 0, and writes to those bits have no effect.
- R7: When CNT_W < 32, a read or write to any high-word address (0xB80, 0xB82, 0xC80, 0xC82) raises csr_illegal_o, returns 0, and leaves both counters unchanged. When CNT_W >= 32, these addresses are legal.
- R8: The user aliases return the same data as the matching machine address. The aliases are 0xC00 for cycle low, 0xC80 for cycle high, 0xC02 for retire low and 0xC82 for retire high. A write to an alias raises csr_illegal_o and changes nothing.
- R9: small_cnt_o is 1 exactly when CNT_W < 64. no_cnt_o is 1 exactly when CNT_W = 0.
- R10: A read or write to any address outside the eight counter addresses raises csr_illegal_o and returns 0. csr_illegal_o is 0 whenever neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_re_i | input | 1 | CSR read strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| inhibit_i | input | 2 | Count inhibit: bit 0 for the cycle counter, bit 1 for the retire counter |
| retire_i | input | 1 | One-cycle pulse for each retired instruction |
| csr_rdata_o | output | 32 | Read data; 0 when there is no legal read |
| csr_illegal_o | output | 1 | The current access is illegal |
| small_cnt_o | output | 1 | The counters are narrower than 64 bits |
| no_cnt_o | output | 1 | No counter bits are implemented |

## Verification
The bench instantiates the unit at widths 64, 40, 20 and 0, drives all four with the same stimulus, and compares every read against a behavioural model on every cycle.

- **Free counting, inhibited counting and sparse retire pulses** separate the increment conditions of the two counters.
- **Writes of all-ones and near-overflow values** exercise several behaviours: carry into the high word, wrapping at each width, masking of the upper bits, and the priority of a write over the increment in the same cycle.
- **High-word accesses, alias writes and unmapped addresses** are issued to each width. Comparing the widths tells an absent word apart from a masked one, and an illegal write apart from one that is silently dropped.

// File: rtl/cnt_csr_pkg.sv
package cnt_csr_pkg;
  localparam logic [11:0] ADDR_CYC_M  = 12'hB00;
  localparam logic [11:0] ADDR_RET_M  = 12'hB02;
  localparam logic [11:0] ADDR_CYC_MH = 12'hB80;
  localparam logic [11:0] ADDR_RET_MH = 12'hB82;
  localparam logic [11:0] ADDR_CYC_U  = 12'hC00;
  localparam logic [11:0] ADDR_RET_U  = 12'hC02;
  localparam logic [11:0] ADDR_CYC_UH = 12'hC80;
  localparam logic [11:0] ADDR_RET_UH = 12'hC82;

  localparam int unsigned NUM_CTR = 2;

  typedef enum logic {CTR_CYCLE = 1'b0, CTR_RETIRE = 1'b1} ctr_id_e;

  typedef struct packed {
    logic    hit;
    logic    user;
    logic    hi;
    ctr_id_e id;
  } csr_dec_t;

  function automatic logic [63:0] width_mask(int unsigned w);
    return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction
endpackage

// File: rtl/cnt_csr_dec.sv
module cnt_csr_dec
  import cnt_csr_pkg::*;
(
  input  logic [11:0] addr_i,
  output csr_dec_t    dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (addr_i)
      ADDR_CYC_M:  dec_o = '{hit: 1'b1, user: 1'b0, hi: 1'b0, id: CTR_CYCLE};
      ADDR_RET_M:  dec_o = '{hit: 1'b1, user: 1'b0, hi: 1'b0, id: CTR_RETIRE};
      ADDR_CYC_MH: dec_o = '{hit: 1'b1, user: 1'b0, hi: 1'b1, id: CTR_CYCLE};
      ADDR_RET_MH: dec_o = '{hit: 1'b1, user: 1'b0, hi: 1'b1, id: CTR_RETIRE};
      ADDR_CYC_U:  dec_o = '{hit: 1'b1, user: 1'b1, hi: 1'b0, id: CTR_CYCLE};
      ADDR_RET_U:  dec_o = '{hit: 1'b1, user: 1'b1, hi: 1'b0, id: CTR_RETIRE};
      ADDR_CYC_UH: dec_o = '{hit: 1'b1, user: 1'b1, hi: 1'b1, id: CTR_CYCLE};
      ADDR_RET_UH: dec_o = '{hit: 1'b1, user: 1'b1, hi: 1'b1, id: CTR_RETIRE};
      default:     dec_o = '0;
    endcase
  end
endmodule

// File: rtl/cnt_csr_ctr.sv
module cnt_csr_ctr
  import cnt_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inc_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] val_o
);
  localparam logic [63:0] MASK = width_mask(CNT_W);

  logic [63:0] cnt_q, cnt_d;

  // write beats increment; mask keeps unimplemented bits constant zero
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i)      cnt_d = {cnt_q[63:32], wdata_i};
    else if (wr_hi_i) cnt_d = {wdata_i, cnt_q[31:0]};
    else if (inc_i)   cnt_d = cnt_q + 64'd1;
    cnt_d = cnt_d & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign val_o = cnt_q;
endmodule

// File: rtl/cnt_csr_unit.sv
module cnt_csr_unit
  import cnt_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic        csr_re_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  input  logic [1:0]  inhibit_i,
  input  logic        retire_i,
  output logic [31:0] csr_rdata_o,
  output logic        csr_illegal_o,
  output logic        small_cnt_o,
  output logic        no_cnt_o
);
  localparam bit HI_PRESENT = (CNT_W >= 32);

  csr_dec_t    dec;
  logic        access, legal;
  logic [63:0] cnt_val [NUM_CTR];
  logic [63:0] cyc_val, ret_val;
  logic [NUM_CTR-1:0] inc, wr;

  cnt_csr_dec u_dec (
    .addr_i (csr_addr_i),
    .dec_o  (dec)
  );

  assign access = csr_we_i | csr_re_i;
  assign legal  = dec.hit && !(dec.hi && !HI_PRESENT) && !(dec.user && csr_we_i);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    if (g == int'(CTR_CYCLE)) begin : g_cyc
      assign inc[g] = !inhibit_i[g];
    end else begin : g_ret
      assign inc[g] = retire_i && !inhibit_i[g];
    end
    assign wr[g] = csr_we_i && legal && (dec.id == ctr_id_e'(g));

    cnt_csr_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[g]),
      .wr_lo_i (wr[g] && !dec.hi),
      .wr_hi_i (wr[g] && dec.hi),
      .wdata_i (csr_wdata_i),
      .val_o   (cnt_val[g])
    );
  end

  assign cyc_val = cnt_val[CTR_CYCLE];
  assign ret_val = cnt_val[CTR_RETIRE];

  always_comb begin
    csr_rdata_o = '0;
    if (csr_re_i && legal)
      csr_rdata_o = dec.hi ? cnt_val[dec.id][63:32] : cnt_val[dec.id][31:0];
  end

  assign csr_illegal_o = access && !legal;
  assign small_cnt_o   = (CNT_W < 64);
  assign no_cnt_o      = (CNT_W == 0);
endmodule

// File: rtl/cnt_csr_unit_chk.sv
module cnt_csr_unit_chk
  import cnt_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr_we_i,
  input logic        csr_re_i,
  input logic [11:0] csr_addr_i,
  input logic [31:0] csr_wdata_i,
  input logic [1:0]  inhibit_i,
  input logic        retire_i,
  input logic [31:0] csr_rdata_o,
  input logic        csr_illegal_o,
  input logic [63:0] cyc_val,
  input logic [63:0] ret_val
);
  localparam logic [63:0] MASK = width_mask(CNT_W);

  logic cyc_wr, ret_wr, hi_addr;
  assign cyc_wr  = csr_we_i && (csr_addr_i == ADDR_CYC_M || csr_addr_i == ADDR_CYC_MH);
  assign ret_wr  = csr_we_i && (csr_addr_i == ADDR_RET_M || csr_addr_i == ADDR_RET_MH);
  assign hi_addr = (csr_addr_i == ADDR_CYC_MH) || (csr_addr_i == ADDR_RET_MH) ||
                   (csr_addr_i == ADDR_CYC_UH) || (csr_addr_i == ADDR_RET_UH);

  assert_cyc_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_i[0] && !cyc_wr) |=> (cyc_val == (($past(cyc_val) + 64'd1) & MASK)));

  assert_ret_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inhibit_i[1] || !retire_i) && !ret_wr) |=> $stable(ret_val));

  assert_wr_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == ADDR_CYC_M) |=> (cyc_val[31:0] == ($past(csr_wdata_i) & MASK[31:0])));

  assert_no_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((CNT_W < 32) && (csr_re_i || csr_we_i) && hi_addr) |-> (csr_illegal_o && csr_rdata_o == 32'd0));

  assert_user_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i[11:8] == 4'hC) |-> csr_illegal_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !csr_re_i) |-> !csr_illegal_o);
endmodule

bind cnt_csr_unit cnt_csr_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_we_i      (csr_we_i),
  .csr_re_i      (csr_re_i),
  .csr_addr_i    (csr_addr_i),
  .csr_wdata_i   (csr_wdata_i),
  .inhibit_i     (inhibit_i),
  .retire_i      (retire_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .cyc_val       (cyc_val),
  .ret_val       (ret_val)
);

// File: tb/cnt_csr_unit_bench.sv
`timescale 1ns/1ps
module cnt_csr_unit_bench;
  localparam int N = 4;
  int wid [N] = '{64, 40, 20, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0, re = 1'b0, ret = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  inh = '0;
  logic [31:0] rd [N];
  logic        il [N];
  logic        sm [N];
  logic        nc [N];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] m_cyc [N];
  logic [63:0] m_ret [N];

  always #5 clk = ~clk;

  cnt_csr_unit u_cnt_csr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_re_i(re), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .inhibit_i(inh), .retire_i(ret), .csr_rdata_o(rd[0]),
    .csr_illegal_o(il[0]), .small_cnt_o(sm[0]), .no_cnt_o(nc[0]));
  cnt_csr_unit #(.CNT_W(40)) u_cnt_csr_unit_w40 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_re_i(re), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .inhibit_i(inh), .retire_i(ret), .csr_rdata_o(rd[1]),
    .csr_illegal_o(il[1]), .small_cnt_o(sm[1]), .no_cnt_o(nc[1]));
  cnt_csr_unit #(.CNT_W(20)) u_cnt_csr_unit_w20 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_re_i(re), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .inhibit_i(inh), .retire_i(ret), .csr_rdata_o(rd[2]),
    .csr_illegal_o(il[2]), .small_cnt_o(sm[2]), .no_cnt_o(nc[2]));
  cnt_csr_unit #(.CNT_W(0)) u_cnt_csr_unit_w0 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_re_i(re), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .inhibit_i(inh), .retire_i(ret), .csr_rdata_o(rd[3]),
    .csr_illegal_o(il[3]), .small_cnt_o(sm[3]), .no_cnt_o(nc[3]));

  function automatic logic [63:0] msk(int w);
    return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic bit known(logic [11:0] a);
    return a == 12'hB00 || a == 12'hB02 || a == 12'hB80 || a == 12'hB82 ||
           a == 12'hC00 || a == 12'hC02 || a == 12'hC80 || a == 12'hC82;
  endfunction

  function automatic bit exp_il(int k, logic w_, logic r_, logic [11:0] a);
    if (!(w_ || r_)) return 1'b0;
    if (!known(a)) return 1'b1;
    if (a[7] && wid[k] < 32) return 1'b1;
    return w_ && (a[11:8] == 4'hC);
  endfunction

  function automatic logic [31:0] exp_rd(int k, logic w_, logic r_, logic [11:0] a);
    logic [63:0] v;
    if (!r_ || exp_il(k, w_, r_, a)) return 32'd0;
    v = a[1] ? m_ret[k] : m_cyc[k];
    return a[7] ? v[63:32] : v[31:0];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic step(string req, logic w_, logic r_, logic [11:0] a,
                      logic [31:0] d, logic [1:0] ih, logic rt);
    we = w_; re = r_; addr = a; wdata = d; inh = ih; ret = rt;
    #1;
    for (int k = 0; k < N; k++) begin
      chk(req, $sformatf("w%0d rdata@%h", wid[k], a), rd[k], exp_rd(k, w_, r_, a));
      chk(req, $sformatf("w%0d illegal@%h", wid[k], a), {31'd0, il[k]},
          {31'd0, exp_il(k, w_, r_, a)});
    end
    for (int k = 0; k < N; k++) begin
      logic legal_w;
      legal_w = w_ && !exp_il(k, w_, r_, a);
      if (legal_w && !a[1])
        m_cyc[k] = (a[7] ? {d, m_cyc[k][31:0]} : {m_cyc[k][63:32], d}) & msk(wid[k]);
      else if (!ih[0])
        m_cyc[k] = (m_cyc[k] + 64'd1) & msk(wid[k]);
      if (legal_w && a[1])
        m_ret[k] = (a[7] ? {d, m_ret[k][31:0]} : {m_ret[k][63:32], d}) & msk(wid[k]);
      else if (rt && !ih[1])
        m_ret[k] = (m_ret[k] + 64'd1) & msk(wid[k]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_cyc[k] = '0;
      m_ret[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: zero right after reset
    step("R1", 0, 1, 12'hB00, 0, 2'b00, 0);
    step("R1", 0, 1, 12'hB02, 0, 2'b00, 0);
    // R9: width flags
    for (int k = 0; k < N; k++) begin
      chk("R9", $sformatf("w%0d small", wid[k]), {31'd0, sm[k]}, {31'd0, wid[k] < 64});
      chk("R9", $sformatf("w%0d none", wid[k]), {31'd0, nc[k]}, {31'd0, wid[k] == 0});
    end
    // R2: free count, then inhibited
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 12'hB00, 0, 2'b00, 0);
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 12'hB00, 0, 2'b01, 0);
    step("R2", 0, 1, 12'hB00, 0, 2'b00, 0);
    // R3: sparse retires, then inhibited
    for (int i = 0; i < 6; i++) step("R3", 0, 1, 12'hB02, 0, 2'b00, i[0]);
    for (int i = 0; i < 4; i++) step("R3", 0, 1, 12'hB02, 0, 2'b10, 1);
    step("R3", 0, 1, 12'hB02, 0, 2'b00, 1);
    step("R3", 0, 1, 12'hB02, 0, 2'b00, 0);
    // R5: write wins over increment
    step("R5", 1, 0, 12'hB00, 32'h0001_2345, 2'b00, 0);
    step("R5", 0, 1, 12'hB00, 0, 2'b00, 0);
    step("R5", 1, 0, 12'hB02, 32'h0000_0077, 2'b00, 1);
    step("R5", 0, 1, 12'hB02, 0, 2'b00, 0);
    step("R5", 1, 0, 12'hB80, 32'h0000_0003, 2'b00, 0);
    step("R5", 0, 1, 12'hB80, 0, 2'b00, 0);
    step("R5", 0, 1, 12'hB00, 0, 2'b00, 0);
    // R4: carry into high word and wrap
    step("R4", 1, 0, 12'hB00, 32'hFFFF_FFFE, 2'b00, 0);
    for (int i = 0; i < 3; i++) begin
      step("R4", 0, 1, 12'hB00, 0, 2'b00, 0);
      step("R4", 0, 1, 12'hB80, 0, 2'b00, 0);
    end
    step("R4", 1, 0, 12'hB82, 32'hFFFF_FFFF, 2'b00, 0);
    step("R4", 1, 0, 12'hB02, 32'hFFFF_FFFF, 2'b00, 0);
    step("R4", 0, 1, 12'hB82, 0, 2'b00, 1);
    step("R4", 0, 1, 12'hB02, 0, 2'b00, 0);
    step("R4", 0, 1, 12'hB82, 0, 2'b00, 0);
    // R6: upper bits stay zero
    step("R6", 1, 0, 12'hB80, 32'hFFFF_FFFF, 2'b01, 0);
    step("R6", 0, 1, 12'hB80, 0, 2'b01, 0);
    step("R6", 1, 0, 12'hB00, 32'hFFFF_FFFF, 2'b01, 0);
    step("R6", 0, 1, 12'hB00, 0, 2'b01, 0);
    step("R6", 0, 1, 12'hC80, 0, 2'b01, 0);
    // R7: high words absent below 32 bits
    step("R7", 1, 0, 12'hB82, 32'h0000_0001, 2'b11, 0);
    step("R7", 0, 1, 12'hB02, 0, 2'b11, 0);
    step("R7", 0, 1, 12'hB82, 0, 2'b11, 0);
    step("R7", 0, 1, 12'hC82, 0, 2'b11, 0);
    // R8: aliases read-only
    step("R8", 0, 1, 12'hC00, 0, 2'b01, 0);
    step("R8", 0, 1, 12'hC02, 0, 2'b01, 0);
    step("R8", 1, 0, 12'hC00, 32'hDEAD_BEEF, 2'b01, 0);
    step("R8", 0, 1, 12'hB00, 0, 2'b01, 0);
    step("R8", 1, 0, 12'hC82, 32'h1111_1111, 2'b01, 0);
    step("R8", 0, 1, 12'hB82, 0, 2'b01, 0);
    // R10: unmapped addresses and idle
    step("R10", 0, 1, 12'hB01, 0, 2'b00, 0);
    step("R10", 1, 0, 12'h300, 32'h5, 2'b00, 0);
    step("R10", 0, 1, 12'hB03, 0, 2'b00, 0);
    step("R10", 0, 0, 12'hB00, 0, 2'b00, 1);
    step("R10", 0, 1, 12'hB00, 0, 2'b00, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule